// File: doc/BRIEF.md
# Carrier Detect Hysteresis Timer

This block turns a stream of received-level estimates into a single carrier-detect flag for a full-duplex line receiver. Each estimate is a signed number in half-dB steps of dBm, qualified by a strobe. An estimate is classed as carrier present or carrier absent against two thresholds with a dead band between them. Estimates inside the dead band leave the block as it is. The flag changes only after a timed qualification, counted in ticks of an external 1 ms pulse.

A link starts in an acquisition phase. In that phase the flag is raised only by a pulse from the handshake sequencer, and level estimates have no effect. After the link has been up, losing carrier lowers the flag after a loss delay. That delay is 50 ticks at the high line rate and 16 ticks in low-rate mode. A returning carrier raises the flag again after a 100-tick recovery delay. During either delay, an estimate of the opposite sense cancels the pending change, so short excursions never toggle the flag.

Top module: `carrier_detect_qual`

## Requirements
- R1: A strobed level at or above -86 (half-dB units, two's complement, i.e. -43 dBm) counts as carrier present; -87 does not.
- R2: A strobed level at or below -94 (-47 dBm) counts as carrier absent.
- R3: A strobed level strictly between -94 and -86 has no effect on the block. Any level presented while the strobe is low also has no effect.
- R4: With the low-rate flag at 0, once an absent level is seen while detect is on, detect stays on through 49 following ticks and is 0 in the cycle after the 50th tick.
- R5: With the low-rate flag at 1, the loss delay is 16 ticks: detect is still on after 15 ticks and off after the 16th.
- R6: During a pending loss, a present level cancels the delay. A later absent level restarts the full count from zero.
- R7: In the acquisition phase, detect stays 0 whatever the levels and ticks. A handshake-complete pulse sets detect to 1 in the cycle after it is sampled.
- R8: After a dropout, a present level starts a 100-tick recovery. Detect is still 0 after 99 ticks and 1 after the 100th. A handshake pulse after a dropout is ignored.
- R9: During a pending recovery, an absent level cancels the delay. A later present level restarts the full 100-tick count.
- R10: Reset clears detect to 0 and returns the block to the acquisition phase, forgetting any previous link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | LVL_W (10) | Signed received level, half-dB units of dBm |
| level_vld_i | input | 1 | Strobe qualifying level_i for one cycle |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| low_rate_i | input | 1 | 1 selects the short loss delay |
| hs_done_i | input | 1 | Handshake-complete pulse |
| carrier_o | output | 1 | Carrier detect flag |

## Verification
The flag is decoded from the state register, so every result is due one clock after the edge that samples its strobe, tick or handshake pulse. Edges that neither expire a count nor carry a strobe leave the flag unchanged. The bench drives each stimulus on a falling edge and samples on the next falling edge, after exactly one rising edge. For each delay it checks the flag once after one tick short of the limit and again after the final tick, which pins the expiry to the exact tick. Cancellation tests let more ticks pass than the original delay, so a count that failed to restart would show up as a wrong flag.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  typedef enum logic [2:0] {
    ST_ACQ  = 3'd0,
    ST_UP   = 3'd1,
    ST_LOSS = 3'd2,
    ST_DOWN = 3'd3,
    ST_REC  = 3'd4
  } cd_state_e;

  typedef enum logic [1:0] {
    LV_NONE    = 2'd0,
    LV_PRESENT = 2'd1,
    LV_ABSENT  = 2'd2
  } lvl_ev_e;

endpackage

// File: rtl/cdq_level_class.sv
module cdq_level_class
  import cdq_pkg::*;
#(
  parameter int LVL_W  = 10,
  parameter int ON_HDB = -86,
  parameter int OFF_HDB = -94
) (
  input  logic signed [LVL_W-1:0] level_i,
  input  logic                    vld_i,
  output lvl_ev_e                 ev_o
);

  localparam logic signed [LVL_W-1:0] ON_L  = LVL_W'(ON_HDB);
  localparam logic signed [LVL_W-1:0] OFF_L = LVL_W'(OFF_HDB);

  always_comb begin
    ev_o = LV_NONE;
    if (vld_i) begin
      if (level_i >= ON_L)       ev_o = LV_PRESENT;
      else if (level_i <= OFF_L) ev_o = LV_ABSENT;
    end
  end

endmodule

// File: rtl/cdq_delay_timer.sv
module cdq_delay_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire_o = en_i && (cnt_q >= (limit_i - CNT_W'(1)));

  always_comb begin
    cnt_en = clr_i || en_i;
    cnt_d  = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (en_i)     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R6
  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !expire_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

endmodule

// File: rtl/cdq_fsm.sv
module cdq_fsm
  import cdq_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int LOSS_HI_MS = 50,
  parameter int LOSS_LO_MS = 16,
  parameter int REC_MS     = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lvl_ev_e          ev_i,
  input  logic             tick_i,
  input  logic             hs_i,
  input  logic             low_rate_i,
  input  logic             expire_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output logic             carrier_o
);

  localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(LOSS_HI_MS);
  localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(LOSS_LO_MS);
  localparam logic [CNT_W-1:0] LIM_REC = CNT_W'(REC_MS);

  cd_state_e state_q, state_d;
  logic      state_en;
  logic      pending;

  assign pending = (state_q == ST_LOSS) || (state_q == ST_REC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACQ:  if (hs_i) state_d = ST_UP;
      ST_UP:   if (ev_i == LV_ABSENT) state_d = ST_LOSS;
      ST_LOSS: begin
        if (ev_i == LV_PRESENT) state_d = ST_UP;
        else if (expire_i)      state_d = ST_DOWN;
      end
      ST_DOWN: if (ev_i == LV_PRESENT) state_d = ST_REC;
      ST_REC: begin
        if (ev_i == LV_ABSENT) state_d = ST_DOWN;
        else if (expire_i)     state_d = ST_UP;
      end
      default: state_d = ST_ACQ;
    endcase
  end

  always_comb begin
    state_en    = (state_d != state_q);
    tmr_clr_o   = state_en;
    tmr_en_o    = tick_i && pending;
    tmr_limit_o = (state_q == ST_REC) ? LIM_REC : (low_rate_i ? LIM_LO : LIM_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_ACQ;
    else if (state_en) state_q <= state_d;
  end

  assign carrier_o = (state_q == ST_UP) || (state_q == ST_LOSS);

  AST_ACQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && !hs_i) |=> (state_q == ST_ACQ)); // R7
  AST_HS_CONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ && hs_i) |=> carrier_o); // R7
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == LV_NONE && !tick_i && !hs_i) |=> $stable(state_q)); // R3
  AST_DOWN_IGNORES_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOWN && ev_i != LV_PRESENT) |=> (state_q == ST_DOWN)); // R8
  AST_REC_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOWN && ev_i == LV_PRESENT) |=> (state_q == ST_REC)); // R1
  AST_LOSS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UP && ev_i == LV_ABSENT) |=> (state_q == ST_LOSS)); // R2
  AST_REC_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REC && ev_i == LV_ABSENT) |=> (state_q == ST_DOWN)); // R9

endmodule

// File: rtl/carrier_detect_qual.sv
module carrier_detect_qual
  import cdq_pkg::*;
#(
  parameter int LVL_W      = 10,
  parameter int ON_HDB     = -86,
  parameter int OFF_HDB    = -94,
  parameter int LOSS_HI_MS = 50,
  parameter int LOSS_LO_MS = 16,
  parameter int REC_MS     = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [LVL_W-1:0] level_i,
  input  logic                    level_vld_i,
  input  logic                    tick_ms_i,
  input  logic                    low_rate_i,
  input  logic                    hs_done_i,
  output logic                    carrier_o
);

  localparam int MAX_A  = (LOSS_HI_MS > LOSS_LO_MS) ? LOSS_HI_MS : LOSS_LO_MS;
  localparam int MAX_MS = (REC_MS > MAX_A) ? REC_MS : MAX_A;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  lvl_ev_e          ev;
  logic             tmr_clr, tmr_en, tmr_exp;
  logic [CNT_W-1:0] tmr_limit;

  cdq_level_class #(
    .LVL_W  (LVL_W),
    .ON_HDB (ON_HDB),
    .OFF_HDB(OFF_HDB)
  ) u_class (
    .level_i(level_i),
    .vld_i  (level_vld_i),
    .ev_o   (ev)
  );

  cdq_fsm #(
    .CNT_W     (CNT_W),
    .LOSS_HI_MS(LOSS_HI_MS),
    .LOSS_LO_MS(LOSS_LO_MS),
    .REC_MS    (REC_MS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .tick_i     (tick_ms_i),
    .hs_i       (hs_done_i),
    .low_rate_i (low_rate_i),
    .expire_i   (tmr_exp),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en),
    .tmr_limit_o(tmr_limit),
    .carrier_o  (carrier_o)
  );

  cdq_delay_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .expire_o(tmr_exp)
  );

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_o) |-> $past(tick_ms_i)); // R4
  AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_o) |-> ($past(hs_done_i) || $past(tick_ms_i))); // R8

endmodule

// File: tb/carrier_detect_qual_bench.sv
module carrier_detect_qual_bench;

  localparam logic [1:0] OP_LVL  = 2'd0;
  localparam logic [1:0] OP_TICK = 2'd1;
  localparam logic [1:0] OP_HS   = 2'd2;
  localparam logic [1:0] OP_RATE = 2'd3;

  typedef struct packed {
    logic [1:0]         op;
    logic signed [15:0] arg;
    logic               exp;
    logic [3:0]         req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{OP_LVL,  -16'sd80,  1'b0, 4'd7},  // R7 level ignored in acquisition
    '{OP_TICK,  16'sd120, 1'b0, 4'd7},  // R7 ticks ignored in acquisition
    '{OP_HS,    16'sd0,   1'b1, 4'd7},  // R7 handshake raises detect
    '{OP_LVL,  -16'sd90,  1'b1, 4'd3},  // R3 dead band
    '{OP_TICK,  16'sd60,  1'b1, 4'd3},  // R3 no loss started
    '{OP_LVL,  -16'sd94,  1'b1, 4'd2},  // R2 boundary starts loss
    '{OP_TICK,  16'sd49,  1'b1, 4'd4},  // R4 one short
    '{OP_TICK,  16'sd1,   1'b0, 4'd4},  // R4 drop on 50th
    '{OP_HS,    16'sd0,   1'b0, 4'd8},  // R8 handshake ignored after dropout
    '{OP_LVL,  -16'sd87,  1'b0, 4'd1},  // R1 -87 not present
    '{OP_TICK,  16'sd150, 1'b0, 4'd1},  // R1 no recovery from -87
    '{OP_LVL,  -16'sd86,  1'b0, 4'd1},  // R1 boundary starts recovery
    '{OP_TICK,  16'sd99,  1'b0, 4'd8},  // R8 one short
    '{OP_TICK,  16'sd1,   1'b1, 4'd8},  // R8 up on 100th
    '{OP_LVL,  -16'sd100, 1'b1, 4'd6},  // R6 start loss
    '{OP_TICK,  16'sd30,  1'b1, 4'd6},
    '{OP_LVL,  -16'sd60,  1'b1, 4'd6},  // R6 cancel
    '{OP_TICK,  16'sd40,  1'b1, 4'd6},  // R6 past old expiry
    '{OP_LVL,  -16'sd95,  1'b1, 4'd6},  // R6 restart
    '{OP_TICK,  16'sd49,  1'b1, 4'd6},
    '{OP_TICK,  16'sd1,   1'b0, 4'd6},  // R6 full count
    '{OP_LVL,  -16'sd70,  1'b0, 4'd9},  // R9 start recovery
    '{OP_TICK,  16'sd60,  1'b0, 4'd9},
    '{OP_LVL,  -16'sd94,  1'b0, 4'd9},  // R9 cancel
    '{OP_TICK,  16'sd60,  1'b0, 4'd9},  // R9 past old expiry
    '{OP_LVL,  -16'sd86,  1'b0, 4'd9},  // R9 restart
    '{OP_TICK,  16'sd99,  1'b0, 4'd9},
    '{OP_TICK,  16'sd1,   1'b1, 4'd9},  // R9 full count
    '{OP_RATE,  16'sd1,   1'b1, 4'd5},  // R5 low rate
    '{OP_LVL,  -16'sd94,  1'b1, 4'd5},
    '{OP_TICK,  16'sd15,  1'b1, 4'd5},  // R5 one short
    '{OP_TICK,  16'sd1,   1'b0, 4'd5}   // R5 drop on 16th
  };

  logic              clk;
  logic              rst_n;
  logic signed [9:0] level;
  logic              level_vld;
  logic              tick;
  logic              low_rate;
  logic              hs_done;
  logic              carrier;

  int n_checks;
  int n_fail;

  carrier_detect_qual u_carrier_detect_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (level),
    .level_vld_i(level_vld),
    .tick_ms_i  (tick),
    .low_rate_i (low_rate),
    .hs_done_i  (hs_done),
    .carrier_o  (carrier)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic exp, input int req, input string what);
    n_checks++;
    if (carrier !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: carrier actual=%b expected=%b", req, what, carrier, exp);
    end
  endtask

  task automatic do_level(input logic signed [9:0] v, input logic vld);
    @(negedge clk);
    level     = v;
    level_vld = vld;
    @(negedge clk);
    level_vld = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_hs();
    @(negedge clk);
    hs_done = 1'b1;
    @(negedge clk);
    hs_done = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    level     = '0;
    level_vld = 1'b0;
    tick      = 1'b0;
    low_rate  = 1'b0;
    hs_done   = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, 10, "detect low in reset"); // R10
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 10, "detect low after reset"); // R10

    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i].op)
        OP_LVL:  do_level(VEC[i].arg[9:0], 1'b1);
        OP_TICK: do_ticks(int'(VEC[i].arg));
        OP_HS:   do_hs();
        default: begin
          @(negedge clk);
          low_rate = VEC[i].arg[0];
        end
      endcase
      check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R10: reset forgets the link; levels and ticks then have no effect
    low_rate = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_level(-10'sd60, 1'b1);
    do_ticks(120);
    check(1'b0, 10, "no recovery after reset without handshake");
    do_hs();
    check(1'b1, 7, "handshake after reset"); // R7

    // R3: absent level with strobe low is ignored
    do_level(-10'sd120, 1'b0);
    do_ticks(60);
    check(1'b1, 3, "unstrobed absent level");

    // R5 / R4: rate flag back to high restores the 50-tick loss delay
    do_level(-10'sd120, 1'b1);
    do_ticks(20);
    check(1'b1, 4, "high rate survives 20 ticks");
    do_ticks(29);
    check(1'b1, 4, "high rate survives 49 ticks");
    do_ticks(1);
    check(1'b0, 4, "high rate drop on 50th tick");

    summary();
    $finish;
  end

endmodule